// File: doc/BRIEF.md
# Complex vector-matrix multiplier

This pipelined datapath block takes a row vector of two complex numbers and a 2x2 complex matrix, and returns their product as a row vector of two complex numbers. Each issue computes C1 = A1*B11 + A2*B21 and C2 = A1*B12 + A2*B22. Every complex element is packed into 32 bits, with the real (I) part in the upper 16 bits and the imaginary (Q) part in the lower 16 bits, both in signed two's complement. Software builds larger matrix products by issuing several of these operations and adding the results with four-way saturating additions. That tiling lies outside this block.

Two flags travel with each issue. `conj_i` replaces the vector by its complex conjugate before the multiply. `round_i` selects the output format. Without it, each result component is a 32-bit saturated value on the full 128-bit output. With it, each component is rounded to 16 bits and packed into the low 64 bits. A new operation can be accepted on every clock, and every result appears a fixed four cycles after its strobe.

Top module: `cmat_vec_mul`

## Requirements
- R1: Vector element A1 sits at `vec_i[31:0]` and A2 at `vec_i[63:32]`. The matrix is row-major: B11 at `mat_i[31:0]`, B12 at `[63:32]`, B21 at `[95:64]` and B22 at `[127:96]`. Every element holds its real part in bits [31:16] and its imaginary part in [15:0], both signed. The output is Cj = A1*B1j + A2*B2j, using ordinary complex products.
- R2: With `round_i`=0, C1 goes to `res_o[63:0]` and C2 to `res_o[127:64]`. Within each, the real part is in the upper 32 bits and the imaginary part in the lower 32. Each component is the exact sum of four signed 16x16 products.
- R3: With `conj_i`=1, the result is computed from conj(A1) and conj(A2), that is, with the sign of each vector imaginary part negated. Negating -32768 does not wrap.
- R4: With `round_i`=1, each component is floor((sum + 2^15) / 2^16), saturated to the signed 16-bit range. C1 goes to `res_o[31:0]` and C2 to `res_o[63:32]`, with the real part in the upper 16 bits of each. `res_o[127:64]` is zero.
- R5: An operation strobed by `valid_i` at rising edge N shows `valid_o`=1 and its result after rising edge N+3. `valid_o` is 0 in every other cycle.
- R6: Back-to-back operations are accepted on consecutive cycles. Each keeps its own `conj_i` and `round_i` and its own operands.
- R7: The active-low asynchronous reset clears `valid_o` and `res_o`. While `valid_o` is 0, `res_o` keeps the last result.
- R8: In full-precision mode, a sum above 2^31-1 saturates to 0x7FFFFFFF, and a sum below -2^31 saturates to 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| conj_i | input | 1 | Conjugate the vector for this operation |
| round_i | input | 1 | Rounded 16-bit output for this operation |
| vec_i | input | 64 | Row vector A1, A2 |
| mat_i | input | 128 | Matrix B11, B12, B21, B22 |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Result vector C1, C2 |

## Verification
An identity matrix passes the vector straight through, which checks lane order and the real/imaginary halves. A matrix of pure imaginary units on the anti-diagonal checks row/column swaps and the sign of the cross terms. The same operands with and without the conjugate flag show which vector imaginary signs are flipped. Operands of all -32768 and mixed extremes drive both saturation limits in each format, and small values placed on the 2^15 boundary separate round-half-up from truncation. Long runs of random operands, with random modes and random gaps between strobes, check throughput, per-operation mode tracking and hold-while-idle against a behavioural model.

// File: rtl/cmvm_pkg.sv
package cmvm_pkg;
  localparam int unsigned N_ROW = 2;
  localparam int unsigned N_COL = 2;
  localparam int unsigned N_MAT = N_ROW * N_COL;

  function automatic int unsigned prod_w(input int unsigned dw);
    return 2 * dw;
  endfunction

  // headroom for 2*N_ROW products per output component
  function automatic int unsigned acc_w(input int unsigned dw);
    return 2 * dw + $clog2(2 * N_ROW);
  endfunction
endpackage

// File: rtl/cmvm_unpack.sv
module cmvm_unpack
  import cmvm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 conj_i,
  input  logic                 round_i,
  input  logic [2*N_ROW*DW-1:0] vec_i,
  input  logic [2*N_MAT*DW-1:0] mat_i,
  output logic                 vld_o,
  output logic                 conj_o,
  output logic                 rnd_o,
  output logic signed [DW-1:0] a_re_o [N_ROW],
  output logic signed [DW-1:0] a_im_o [N_ROW],
  output logic signed [DW-1:0] b_re_o [N_MAT],
  output logic signed [DW-1:0] b_im_o [N_MAT]
);
  localparam int unsigned EW = 2 * DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      conj_o <= 1'b0;
      rnd_o  <= 1'b0;
      for (int k = 0; k < N_ROW; k++) begin
        a_re_o[k] <= '0;
        a_im_o[k] <= '0;
      end
      for (int e = 0; e < N_MAT; e++) begin
        b_re_o[e] <= '0;
        b_im_o[e] <= '0;
      end
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        conj_o <= conj_i;
        rnd_o  <= round_i;
        for (int k = 0; k < N_ROW; k++) begin
          a_re_o[k] <= vec_i[k*EW+DW +: DW];
          a_im_o[k] <= vec_i[k*EW +: DW];
        end
        for (int e = 0; e < N_MAT; e++) begin
          b_re_o[e] <= mat_i[e*EW+DW +: DW];
          b_im_o[e] <= mat_i[e*EW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/cmvm_mult.sv
module cmvm_mult
  import cmvm_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned PW = prod_w(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 conj_i,
  input  logic                 rnd_i,
  input  logic signed [DW-1:0] a_re_i [N_ROW],
  input  logic signed [DW-1:0] a_im_i [N_ROW],
  input  logic signed [DW-1:0] b_re_i [N_MAT],
  input  logic signed [DW-1:0] b_im_i [N_MAT],
  output logic                 vld_o,
  output logic                 conj_o,
  output logic                 rnd_o,
  output logic signed [PW-1:0] rr_o [N_MAT],
  output logic signed [PW-1:0] ii_o [N_MAT],
  output logic signed [PW-1:0] ri_o [N_MAT],
  output logic signed [PW-1:0] ir_o [N_MAT]
);
  logic signed [PW-1:0] rr_d [N_MAT];
  logic signed [PW-1:0] ii_d [N_MAT];
  logic signed [PW-1:0] ri_d [N_MAT];
  logic signed [PW-1:0] ir_d [N_MAT];

  // product slot j*N_ROW+k pairs vector element k with matrix element (k,j)
  for (genvar j = 0; j < N_COL; j++) begin : g_col
    for (genvar k = 0; k < N_ROW; k++) begin : g_row
      localparam int unsigned P = j * N_ROW + k;
      localparam int unsigned M = k * N_COL + j;
      assign rr_d[P] = PW'(a_re_i[k]) * PW'(b_re_i[M]);
      assign ii_d[P] = PW'(a_im_i[k]) * PW'(b_im_i[M]);
      assign ri_d[P] = PW'(a_re_i[k]) * PW'(b_im_i[M]);
      assign ir_d[P] = PW'(a_im_i[k]) * PW'(b_re_i[M]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      conj_o <= 1'b0;
      rnd_o  <= 1'b0;
      for (int p = 0; p < N_MAT; p++) begin
        rr_o[p] <= '0;
        ii_o[p] <= '0;
        ri_o[p] <= '0;
        ir_o[p] <= '0;
      end
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        conj_o <= conj_i;
        rnd_o  <= rnd_i;
        for (int p = 0; p < N_MAT; p++) begin
          rr_o[p] <= rr_d[p];
          ii_o[p] <= ii_d[p];
          ri_o[p] <= ri_d[p];
          ir_o[p] <= ir_d[p];
        end
      end
    end
  end
endmodule

// File: rtl/cmvm_acc.sv
module cmvm_acc
  import cmvm_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned PW = prod_w(DW),
  localparam int unsigned AW = acc_w(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 conj_i,
  input  logic                 rnd_i,
  input  logic signed [PW-1:0] rr_i [N_MAT],
  input  logic signed [PW-1:0] ii_i [N_MAT],
  input  logic signed [PW-1:0] ri_i [N_MAT],
  input  logic signed [PW-1:0] ir_i [N_MAT],
  output logic                 vld_o,
  output logic                 rnd_o,
  output logic signed [AW-1:0] re_o [N_COL],
  output logic signed [AW-1:0] im_o [N_COL]
);
  logic signed [AW-1:0] re_d [N_COL];
  logic signed [AW-1:0] im_d [N_COL];

  // conjugating the vector flips the sign of every term carrying a vector imaginary part
  always_comb begin
    for (int j = 0; j < N_COL; j++) begin
      logic signed [AW-1:0] s_rr, s_ii, s_ri, s_ir;
      s_rr = '0;
      s_ii = '0;
      s_ri = '0;
      s_ir = '0;
      for (int k = 0; k < N_ROW; k++) begin
        s_rr = s_rr + AW'(rr_i[j*N_ROW+k]);
        s_ii = s_ii + AW'(ii_i[j*N_ROW+k]);
        s_ri = s_ri + AW'(ri_i[j*N_ROW+k]);
        s_ir = s_ir + AW'(ir_i[j*N_ROW+k]);
      end
      re_d[j] = conj_i ? s_rr + s_ii : s_rr - s_ii;
      im_d[j] = conj_i ? s_ri - s_ir : s_ri + s_ir;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      rnd_o <= 1'b0;
      for (int j = 0; j < N_COL; j++) begin
        re_o[j] <= '0;
        im_o[j] <= '0;
      end
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        rnd_o <= rnd_i;
        for (int j = 0; j < N_COL; j++) begin
          re_o[j] <= re_d[j];
          im_o[j] <= im_d[j];
        end
      end
    end
  end
endmodule

// File: rtl/cmvm_fmt.sv
module cmvm_fmt
  import cmvm_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = acc_w(DW)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic                   rnd_i,
  input  logic signed [AW-1:0]   re_i [N_COL],
  input  logic signed [AW-1:0]   im_i [N_COL],
  output logic                   vld_o,
  output logic [4*N_COL*DW-1:0]  res_o
);
  localparam int unsigned PW  = prod_w(DW);
  localparam int unsigned RW  = AW + 1;
  localparam logic signed [AW-1:0] F_MAX = {{(AW-PW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic signed [AW-1:0] F_MIN = {{(AW-PW+1){1'b1}}, {(PW-1){1'b0}}};
  localparam logic signed [RW-1:0] R_MAX = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] R_MIN = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [RW-1:0] R_HALF = {{(RW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

  function automatic logic [PW-1:0] sat_full(input logic signed [AW-1:0] x);
    if (x > F_MAX) return F_MAX[PW-1:0];
    if (x < F_MIN) return F_MIN[PW-1:0];
    return x[PW-1:0];
  endfunction

  function automatic logic [DW-1:0] sat_rnd(input logic signed [AW-1:0] x);
    logic signed [RW-1:0] t;
    t = ($signed({x[AW-1], x}) + R_HALF) >>> DW;
    if (t > R_MAX) return R_MAX[DW-1:0];
    if (t < R_MIN) return R_MIN[DW-1:0];
    return t[DW-1:0];
  endfunction

  logic [4*N_COL*DW-1:0] res_d;

  always_comb begin
    res_d = '0;
    for (int j = 0; j < N_COL; j++) begin
      if (rnd_i) res_d[j*2*DW +: 2*DW] = {sat_rnd(re_i[j]), sat_rnd(im_i[j])};
      else       res_d[j*2*PW +: 2*PW] = {sat_full(re_i[j]), sat_full(im_i[j])};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/cmat_vec_mul.sv
module cmat_vec_mul
  import cmvm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   conj_i,
  input  logic                   round_i,
  input  logic [2*N_ROW*DW-1:0]  vec_i,
  input  logic [2*N_MAT*DW-1:0]  mat_i,
  output logic                   valid_o,
  output logic [4*N_COL*DW-1:0]  res_o
);
  localparam int unsigned PW = prod_w(DW);
  localparam int unsigned AW = acc_w(DW);

  logic                 s1_vld, s1_conj, s1_rnd;
  logic signed [DW-1:0] a_re [N_ROW];
  logic signed [DW-1:0] a_im [N_ROW];
  logic signed [DW-1:0] b_re [N_MAT];
  logic signed [DW-1:0] b_im [N_MAT];

  logic                 s2_vld, s2_conj, s2_rnd;
  logic signed [PW-1:0] rr [N_MAT];
  logic signed [PW-1:0] ii [N_MAT];
  logic signed [PW-1:0] ri [N_MAT];
  logic signed [PW-1:0] ir [N_MAT];

  logic                 s3_vld, s3_rnd;
  logic signed [AW-1:0] acc_re [N_COL];
  logic signed [AW-1:0] acc_im [N_COL];

  cmvm_unpack #(.DW(DW)) i_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .conj_i  (conj_i),
    .round_i (round_i),
    .vec_i   (vec_i),
    .mat_i   (mat_i),
    .vld_o   (s1_vld),
    .conj_o  (s1_conj),
    .rnd_o   (s1_rnd),
    .a_re_o  (a_re),
    .a_im_o  (a_im),
    .b_re_o  (b_re),
    .b_im_o  (b_im)
  );

  cmvm_mult #(.DW(DW)) i_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .conj_i (s1_conj),
    .rnd_i  (s1_rnd),
    .a_re_i (a_re),
    .a_im_i (a_im),
    .b_re_i (b_re),
    .b_im_i (b_im),
    .vld_o  (s2_vld),
    .conj_o (s2_conj),
    .rnd_o  (s2_rnd),
    .rr_o   (rr),
    .ii_o   (ii),
    .ri_o   (ri),
    .ir_o   (ir)
  );

  cmvm_acc #(.DW(DW)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s2_vld),
    .conj_i (s2_conj),
    .rnd_i  (s2_rnd),
    .rr_i   (rr),
    .ii_i   (ii),
    .ri_i   (ri),
    .ir_i   (ir),
    .vld_o  (s3_vld),
    .rnd_o  (s3_rnd),
    .re_o   (acc_re),
    .im_o   (acc_im)
  );

  cmvm_fmt #(.DW(DW)) i_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s3_vld),
    .rnd_i  (s3_rnd),
    .re_i   (acc_re),
    .im_i   (acc_im),
    .vld_o  (valid_o),
    .res_o  (res_o)
  );
endmodule

// File: rtl/cmvm_chk.sv
module cmvm_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          round_i,
  input logic [4*DW-1:0] vec_i,
  input logic          valid_o,
  input logic [8*DW-1:0] res_o
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(valid_i, 4))); // R5

  AST_RND_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && $past(valid_i && round_i, 4)) |-> (res_o[8*DW-1:4*DW] == '0)); // R4

  AST_ZERO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && $past(valid_i && (vec_i == '0), 4)) |-> (res_o == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd0 && !valid_o) |-> $stable(res_o)); // R7
endmodule

bind cmat_vec_mul cmvm_chk #(.DW(DW)) i_cmvm_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .round_i (round_i),
  .vec_i   (vec_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/test_cmat_vec_mul.sv
`timescale 1ns/1ps
module test_cmat_vec_mul;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         conj_i = 1'b0;
  logic         round_i = 1'b0;
  logic [63:0]  vec_i = '0;
  logic [127:0] mat_i = '0;
  logic         valid_o;
  logic [127:0] res_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic         pv [4];
  logic [127:0] pd [4];
  string        pt [4];
  logic [127:0] hold_res = '0;

  always #2.5 clk_i = ~clk_i;

  cmat_vec_mul i_cmat_vec_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .conj_i  (conj_i),
    .round_i (round_i),
    .vec_i   (vec_i),
    .mat_i   (mat_i),
    .valid_o (valid_o),
    .res_o   (res_o)
  );

  function automatic logic [31:0] cx(input int re, input int im);
    return {16'(re), 16'(im)};
  endfunction

  function automatic logic [31:0] sat32(input longint x);
    if (x > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (x < -64'sd2147483648) return 32'h8000_0000;
    return x[31:0];
  endfunction

  function automatic logic [15:0] sat16(input longint x);
    if (x > 64'sd32767)  return 16'h7FFF;
    if (x < -64'sd32768) return 16'h8000;
    return x[15:0];
  endfunction

  function automatic logic [127:0] ref_model(input logic c, input logic r,
                                             input logic [63:0] a, input logic [127:0] m);
    logic [127:0] o;
    o = '0;
    for (int j = 0; j < 2; j++) begin
      longint re, im;
      re = 0;
      im = 0;
      for (int k = 0; k < 2; k++) begin
        longint ar, ai, br, bi;
        ar = longint'($signed(a[k*32+16 +: 16]));
        ai = longint'($signed(a[k*32 +: 16]));
        br = longint'($signed(m[(k*2+j)*32+16 +: 16]));
        bi = longint'($signed(m[(k*2+j)*32 +: 16]));
        if (c) begin
          re += ar*br + ai*bi;
          im += ar*bi - ai*br;
        end else begin
          re += ar*br - ai*bi;
          im += ar*bi + ai*br;
        end
      end
      if (r) o[j*32 +: 32] = {sat16((re + 32768) >>> 16), sat16((im + 32768) >>> 16)};
      else   o[j*64 +: 64] = {sat32(re), sat32(im)};
    end
    return o;
  endfunction

  task automatic chk_val(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic c, input logic r,
                      input logic [63:0] a, input logic [127:0] m, input string tag);
    valid_i = v;
    conj_i  = c;
    round_i = r;
    vec_i   = a;
    mat_i   = m;
    @(posedge clk_i);
    for (int i = 3; i > 0; i--) begin
      pv[i] = pv[i-1];
      pd[i] = pd[i-1];
      pt[i] = pt[i-1];
    end
    pv[0] = v;
    pd[0] = v ? ref_model(c, r, a, m) : '0;
    pt[0] = tag;
    @(negedge clk_i);
    chk_val("R5 valid", {127'd0, valid_o}, {127'd0, pv[3]});
    if (pv[3]) begin
      hold_res = pd[3];
      chk_val(pt[3], res_o, hold_res);
    end else begin
      chk_val("R7 hold", res_o, hold_res);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "R7");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] ident, swap, all_min, mixed, r_pos;
    for (int i = 0; i < 4; i++) begin
      pv[i] = 1'b0;
      pd[i] = '0;
      pt[i] = "";
    end
    repeat (3) @(negedge clk_i);
    chk_val("R7 reset valid", {127'd0, valid_o}, 128'd0);
    chk_val("R7 reset data", res_o, 128'd0);
    rst_ni = 1'b1;

    ident   = {cx(1, 0), cx(0, 0), cx(0, 0), cx(1, 0)};
    swap    = {cx(0, 0), cx(0, 1), cx(0, 1), cx(0, 0)};
    all_min = {4{cx(-32768, -32768)}};
    mixed   = {4{cx(32767, 32767)}};
    r_pos   = {cx(0, 0), cx(0, 0), cx(0, 0), cx(16384, 0)};

    // identity passes the vector through (R1, R2)
    step(1'b1, 1'b0, 1'b0, {cx(-1000, 55), cx(300, -7)}, ident, "R1 identity");
    step(1'b1, 1'b0, 1'b0, {cx(-1000, 55), cx(300, -7)}, swap, "R1 swap");
    step(1'b1, 1'b1, 1'b0, {cx(-1000, 55), cx(300, -7)}, ident, "R3 conj identity");
    step(1'b1, 1'b1, 1'b0, {cx(-32768, -32768), cx(5, -32768)}, swap, "R3 conj min");
    idle(4);
    // saturation, full precision (R8)
    step(1'b1, 1'b1, 1'b0, {2{cx(-32768, -32768)}}, all_min, "R8 pos sat conj");
    step(1'b1, 1'b0, 1'b0, {2{cx(-32768, -32768)}}, all_min, "R8 pos sat im");
    step(1'b1, 1'b0, 1'b0, {2{cx(-32768, -32768)}}, mixed, "R8 neg sat");
    step(1'b1, 1'b0, 1'b0, {cx(12345, -321), cx(-7, 999)}, {cx(3, 4), cx(-5, 6), cx(7, -8), cx(9, 10)}, "R2 small");
    idle(3);
    // rounding boundaries (R4)
    step(1'b1, 1'b0, 1'b1, {cx(0, 0), cx(2, 0)}, r_pos, "R4 half up");
    step(1'b1, 1'b0, 1'b1, {cx(0, 0), cx(-2, 0)}, r_pos, "R4 neg half");
    step(1'b1, 1'b0, 1'b1, {cx(0, 0), cx(1, 0)}, r_pos, "R4 below half");
    step(1'b1, 1'b1, 1'b1, {2{cx(-32768, -32768)}}, all_min, "R4 rnd sat pos");
    step(1'b1, 1'b0, 1'b1, {2{cx(-32768, -32768)}}, mixed, "R4 rnd sat neg");
    step(1'b1, 1'b0, 1'b0, '0, mixed, "R1 zero vec");
    idle(5);
    // random back-to-back with random modes and gaps (R6)
    for (int n = 0; n < 400; n++) begin
      logic [63:0]  a;
      logic [127:0] m;
      a = {$urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      if (n % 7 == 3) a = {a[63:48], 16'h8000, a[31:0]};
      step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), a, m, "R6 random");
    end
    idle(6);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule